// File: doc/BRIEF.md
# Match-Compare Timer with Watchdog Channel

This block is a memory-mapped timer. A free-running up-counter advances by one on each cycle where the tick enable is high. A bank of compare channels watches that counter. When the counter steps onto the value held in a channel's match register, the channel raises a sticky status bit. That status bit drives the channel's interrupt output while the channel's interrupt-enable bit is set.

One channel, index 5 by default, is set aside as the watchdog. Software arms or restarts it in four steps: write 1 to the snapshot register, read the captured count, add the timeout in ticks, and write the sum to the watchdog channel's match register. Software computes the time left as match minus counter, modulo the counter width. A hit on the watchdog channel raises the system reset request only when two bits are set: that channel's interrupt-enable bit and the separate watchdog-enable bit. Once raised, the request stays high until the block itself is reset.

The register bus is a plain single-cycle interface. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`.

Top module: `match_timer_wdt`

## Requirements
- R1: After reset the counter, snapshot, match registers, status, interrupt enables and watchdog enable all read zero, `irq` is zero and `wdt_reset_req` is low.
- R2: The counter reads at byte offset 0x00. It increases by exactly one on each clock edge where `tick` is high, holds otherwise, and wraps modulo 2^CNT_W.
- R3: Writing a value with bit 0 set to offset 0x30 copies the counter into the snapshot, which reads at offset 0x34. The snapshot keeps its value while the counter runs on. A write to 0x30 with bit 0 clear captures nothing, and 0x30 reads zero.
- R4: Channel n's match register is read/write at offset 0x08 + 4·n.
- R5: Status bit n is set at the edge where a tick moves the counter onto match n. The compare is an equality test, so a match value numerically below the counter fires after the counter wraps. A match equal to the current count does not fire until the counter comes round again.
- R6: The status register at offset 0x20 reads one bit per channel. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R7: The interrupt-enable register at offset 0x24 holds bit n for channel n, and `irq[n]` is high exactly when status bit n and enable bit n are both set.
- R8: Bit 0 of offset 0x28 is the watchdog enable. Writing 1 turns the watchdog on and writing 0 turns it off.
- R9: `wdt_reset_req` rises at the edge where the watchdog channel hits, and only if both its interrupt-enable bit and the watchdog enable are set. With the interrupt bit clear, a hit raises no request even when the watchdog is enabled. After a restart to snapshot + T, the request rises after exactly T ticks.
- R10: Once high, `wdt_reset_req` stays high through any bus writes until `rst_n` is asserted.
- R11: Reads of unmapped offsets return zero. Writes to the read-only offsets 0x00 and 0x34 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advance enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | NUM_CH | Per-channel interrupt outputs |
| wdt_reset_req | output | 1 | Sticky system reset request |

## Verification
The bench builds the block with CNT_W set to 12 and keeps six channels, with the watchdog on channel 5. The narrow counter lets the bench drive it through a full wrap within a few thousand ticks. That makes the case of a match value behind the counter reachable, which a 32-bit counter would never reach in simulation. With this width the bench can also watch the modulo arithmetic for time remaining and the exact tick on which a restarted watchdog fires.

// File: rtl/mtw_pkg.sv
package mtw_pkg;
  localparam int BUS_W       = 32;
  localparam int OFF_COUNT   = 'h00;
  localparam int OFF_MATCH0  = 'h08;
  localparam int OFF_STATUS  = 'h20;
  localparam int OFF_IEN     = 'h24;
  localparam int OFF_WDEN    = 'h28;
  localparam int OFF_SNAPCMD = 'h30;
  localparam int OFF_SNAP    = 'h34;

  // byte offset of compare channel idx
  function automatic int match_offset(input int idx);
    return OFF_MATCH0 + 4 * idx;
  endfunction

  // counter value after one tick, wrapping at width w
  function automatic logic [BUS_W-1:0] step_count(input logic [BUS_W-1:0] v,
                                                  input int w);
    logic [BUS_W-1:0] m;
    m = (w >= BUS_W) ? '1 : ((BUS_W'(1) << w) - 1);
    return (v + 1) & m;
  endfunction

  // ticks until a match, modulo width w
  function automatic logic [BUS_W-1:0] ticks_left(input logic [BUS_W-1:0] match,
                                                  input logic [BUS_W-1:0] cnt,
                                                  input int w);
    logic [BUS_W-1:0] m;
    m = (w >= BUS_W) ? '1 : ((BUS_W'(1) << w) - 1);
    return (match - cnt) & m;
  endfunction
endpackage

// File: rtl/mtw_counter.sv
module mtw_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             snap_cmd,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next,
  output logic [CNT_W-1:0] snap_q
);
  import mtw_pkg::*;

  logic [BUS_W-1:0] stepped;

  always_comb begin
    stepped  = step_count(BUS_W'(cnt_q), CNT_W);
    cnt_next = stepped[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else begin
      if (tick)     cnt_q  <= cnt_next;
      if (snap_cmd) snap_q <= cnt_q;
    end
  end
endmodule

// File: rtl/mtw_match_bank.sv
module mtw_match_bank #(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic [CNT_W-1:0]             cnt_next,
  input  logic [NUM_CH-1:0]            match_we,
  input  logic [CNT_W-1:0]             match_wdata,
  input  logic [NUM_CH-1:0]            clr_mask,
  output logic [NUM_CH-1:0][CNT_W-1:0] match_q,
  output logic [NUM_CH-1:0]            hit_vec,
  output logic [NUM_CH-1:0]            status_q
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // a hit is the counter stepping onto the match value
    assign hit_vec[i] = tick && (cnt_next == match_q[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        match_q[i]  <= '0;
        status_q[i] <= 1'b0;
      end else begin
        if (match_we[i]) match_q[i] <= match_wdata;
        if (hit_vec[i])       status_q[i] <= 1'b1;
        else if (clr_mask[i]) status_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mtw_wdt_ctrl.sv
module mtw_wdt_ctrl #(
  parameter int NUM_CH = 6,
  parameter int WDT_CH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ien_we,
  input  logic              wden_we,
  input  logic [NUM_CH-1:0] ien_wdata,
  input  logic              wden_wdata,
  input  logic [NUM_CH-1:0] hit_vec,
  output logic [NUM_CH-1:0] ien_q,
  output logic              wden_q,
  output logic              wdt_fire,
  output logic              reset_req_q
);
  assign wdt_fire = hit_vec[WDT_CH] && ien_q[WDT_CH] && wden_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q       <= '0;
      wden_q      <= 1'b0;
      reset_req_q <= 1'b0;
    end else begin
      if (ien_we)   ien_q  <= ien_wdata;
      if (wden_we)  wden_q <= wden_wdata;
      if (wdt_fire) reset_req_q <= 1'b1;
    end
  end
endmodule

// File: rtl/match_timer_wdt.sv
module match_timer_wdt #(
  parameter int NUM_CH = 6,
  parameter int WDT_CH = 5,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq,
  output logic              wdt_reset_req
);
  import mtw_pkg::*;

  localparam logic [ADDR_W-1:0] A_COUNT   = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_IEN     = ADDR_W'(OFF_IEN);
  localparam logic [ADDR_W-1:0] A_WDEN    = ADDR_W'(OFF_WDEN);
  localparam logic [ADDR_W-1:0] A_SNAP    = ADDR_W'(OFF_SNAP);
  localparam logic [ADDR_W-1:0] A_SNAPCMD = ADDR_W'(OFF_SNAPCMD);

  // named internal events
  logic [CNT_W-1:0]             cnt_q, cnt_next, snap_q;
  logic                         snap_cmd;
  logic [NUM_CH-1:0]            match_we, hit_vec, status_q, clr_mask, ien_q;
  logic [NUM_CH-1:0][CNT_W-1:0] match_q;
  logic                         ien_we, wden_we, wden_q, wdt_fire, reset_req_q;

  assign snap_cmd = bus_wr && (bus_addr == A_SNAPCMD) && bus_wdata[0];
  assign ien_we   = bus_wr && (bus_addr == A_IEN);
  assign wden_we  = bus_wr && (bus_addr == A_WDEN);
  assign clr_mask = (bus_wr && (bus_addr == A_STATUS)) ? bus_wdata[NUM_CH-1:0] : '0;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_we
    assign match_we[i] = bus_wr && (bus_addr == ADDR_W'(match_offset(i)));
  end

  mtw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .snap_cmd(snap_cmd),
    .cnt_q(cnt_q), .cnt_next(cnt_next), .snap_q(snap_q)
  );

  mtw_match_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_next(cnt_next),
    .match_we(match_we), .match_wdata(bus_wdata[CNT_W-1:0]),
    .clr_mask(clr_mask), .match_q(match_q), .hit_vec(hit_vec),
    .status_q(status_q)
  );

  mtw_wdt_ctrl #(.NUM_CH(NUM_CH), .WDT_CH(WDT_CH)) u_wdt (
    .clk(clk), .rst_n(rst_n), .ien_we(ien_we), .wden_we(wden_we),
    .ien_wdata(bus_wdata[NUM_CH-1:0]), .wden_wdata(bus_wdata[0]),
    .hit_vec(hit_vec), .ien_q(ien_q), .wden_q(wden_q),
    .wdt_fire(wdt_fire), .reset_req_q(reset_req_q)
  );

  assign irq           = status_q & ien_q;
  assign wdt_reset_req = reset_req_q;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_COUNT:  bus_rdata = 32'(cnt_q);
      A_SNAP:   bus_rdata = 32'(snap_q);
      A_STATUS: bus_rdata = 32'(status_q);
      A_IEN:    bus_rdata = 32'(ien_q);
      A_WDEN:   bus_rdata = 32'(wden_q);
      default: begin
        for (int i = 0; i < NUM_CH; i++)
          if (bus_addr == ADDR_W'(match_offset(i))) bus_rdata = 32'(match_q[i]);
      end
    endcase
  end
endmodule

// File: rtl/mtw_checker.sv
module mtw_checker #(
  parameter int NUM_CH = 6,
  parameter int WDT_CH = 5,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              snap_cmd,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  snap_q,
  input logic [NUM_CH-1:0] hit_vec,
  input logic [NUM_CH-1:0] status_q,
  input logic [NUM_CH-1:0] ien_q,
  input logic              wden_q,
  input logic              wdt_reset_req
);
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  p_snap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_cmd |=> $stable(snap_q));

  p_hit_sets_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |=> ((status_q & $past(hit_vec)) == $past(hit_vec)));

  p_reset_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_reset_req) |-> $past(hit_vec[WDT_CH] && ien_q[WDT_CH] && wden_q));

  p_reset_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_req |=> wdt_reset_req);
endmodule

bind match_timer_wdt mtw_checker #(.NUM_CH(NUM_CH), .WDT_CH(WDT_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .snap_cmd(snap_cmd),
  .cnt_q(cnt_q), .snap_q(snap_q), .hit_vec(hit_vec), .status_q(status_q),
  .ien_q(ien_q), .wden_q(wden_q), .wdt_reset_req(wdt_reset_req)
);

// File: tb/test_match_timer_wdt.sv
module test_match_timer_wdt;
  localparam int NCH = 6;
  localparam int WCH = 5;
  localparam int CW  = 12;
  localparam logic [31:0] CMASK = (32'd1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] irq;
  logic        wdt_reset_req;

  int total = 0;
  int bad = 0;
  logic [31:0] m_cnt = '0;

  match_timer_wdt #(.NUM_CH(NCH), .WDT_CH(WCH), .CNT_W(CW), .ADDR_W(8)) i_match_timer_wdt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .wdt_reset_req(wdt_reset_req)
  );

  always #5 clk = ~clk;

  // bench's own count of ticked edges
  always @(posedge clk) begin
    if (!rst_n) m_cnt <= '0;
    else if (tick) m_cnt <= (m_cnt + 1) & CMASK;
  end

  function automatic logic [31:0] chan_off(input int n);
    return 32'h8 + 32'(n) * 4;
  endfunction

  function automatic logic [31:0] remaining(input logic [31:0] mt, input logic [31:0] c);
    return (mt + (CMASK + 1) - c) & CMASK;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic run(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(posedge clk);
      #1 tick = 1'b0;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, s, c, mt;
    void'($urandom(32'h5eed));
    do_reset();

    // R1 reset state
    rd(8'h00, v); check("R1 counter", v, 0);
    rd(8'h34, v); check("R1 snapshot", v, 0);
    rd(8'h20, v); check("R1 status", v, 0);
    rd(8'h24, v); check("R1 ien", v, 0);
    rd(8'h28, v); check("R1 wden", v, 0);
    for (int n = 0; n < NCH; n++) begin rd(chan_off(n)[7:0], v); check("R1 match", v, 0); end
    check("R1 irq", 32'(irq), 0);
    check("R1 reset_req", 32'(wdt_reset_req), 0);

    // R2 counting
    run(17); rd(8'h00, v); check("R2 count", v, 17);
    repeat (4) @(posedge clk); rd(8'h00, v); check("R2 hold", v, 17);

    // R3 snapshot
    wr(8'h30, 1); rd(8'h34, s); check("R3 capture", s, m_cnt);
    run(7); rd(8'h34, v); check("R3 stable", v, s);
    rd(8'h00, v); check("R3 live moves", v, (s + 7) & CMASK);
    wr(8'h30, 0); rd(8'h34, v); check("R3 bit0 clear no capture", v, s);
    rd(8'h30, v); check("R3 cmd reads zero", v, 0);

    // R4 match registers
    for (int n = 0; n < NCH; n++) wr(chan_off(n)[7:0], 32'h100 + 32'(n) * 3);
    for (int n = 0; n < NCH; n++) begin rd(chan_off(n)[7:0], v); check("R4 match rw", v, 32'h100 + 32'(n) * 3); end

    // R11 unmapped / read-only
    rd(8'h04, v); check("R11 unmapped 04", v, 0);
    rd(8'h3C, v); check("R11 unmapped 3C", v, 0);
    c = m_cnt;
    wr(8'h00, 32'h0AB); rd(8'h00, v); check("R11 count ro", v, c);
    wr(8'h34, 32'h0CD); rd(8'h34, v); check("R11 snap ro", v, s);

    // R5 match equal to current count does not fire immediately
    wr(8'h20, 32'h3F);
    wr(chan_off(0)[7:0], m_cnt); run(1);
    rd(8'h20, v); check("R5 equal no fire", v & 1, 0);

    // R5 wrap: match behind counter
    c = m_cnt; mt = (c - 3) & CMASK;
    wr(8'h20, 32'h3F); wr(chan_off(1)[7:0], mt);
    run(32'(remaining(mt, c)) - 1);
    rd(8'h20, v); check("R5 before wrap hit", (v >> 1) & 1, 0);
    run(1);
    rd(8'h20, v); check("R5 wrap hit", (v >> 1) & 1, 1);
    rd(8'h00, v); check("R2 wrapped count", v, mt);

    // R6 write-one-to-clear
    wr(8'h20, 0); rd(8'h20, v); check("R6 zero write keeps", (v >> 1) & 1, 1);
    wr(8'h20, 32'h2); rd(8'h20, v); check("R6 w1c", (v >> 1) & 1, 0);

    // R7 interrupt gating
    c = m_cnt; wr(chan_off(2)[7:0], (c + 2) & CMASK); wr(chan_off(3)[7:0], (c + 2) & CMASK);
    wr(8'h24, 32'h4); run(2);
    check("R7 irq gated", 32'(irq) & 32'hC, 32'h4);
    rd(8'h24, v); check("R7 ien read", v, 32'h4);
    wr(8'h24, 32'hC); check("R7 irq enabled", 32'(irq) & 32'hC, 32'hC);
    wr(8'h20, 32'h3F); wr(8'h24, 0);

    // random mix against the bench model (R5, R2)
    for (int it = 0; it < 60; it++) begin
      int ch, d, k;
      ch = int'($urandom % NCH); d = 1 + int'($urandom % 30); k = int'($urandom % 31);
      c = m_cnt;
      wr(8'h20, 32'h3F);
      wr(chan_off(ch)[7:0], (c + 32'(d)) & CMASK);
      run(k);
      rd(8'h20, v); check("R5 random hit", (v >> ch) & 1, (d <= k) ? 1 : 0);
      rd(8'h00, v); check("R2 random count", v, m_cnt);
    end

    // R8 / R9: watchdog enable without interrupt bit gives no reset
    wr(8'h20, 32'h3F);
    wr(8'h28, 1); rd(8'h28, v); check("R8 wden set", v, 1);
    wr(chan_off(WCH)[7:0], (m_cnt + 3) & CMASK); run(5);
    rd(8'h20, v); check("R9 status without ien", (v >> WCH) & 1, 1);
    check("R9 no reset when ien clear", 32'(wdt_reset_req), 0);
    wr(8'h28, 0); rd(8'h28, v); check("R8 wden clear", v, 0);

    // interrupt bit set, watchdog off: no reset
    wr(8'h20, 32'h3F); wr(8'h24, 32'(1) << WCH);
    wr(8'h30, 1); rd(8'h34, s); wr(chan_off(WCH)[7:0], (s + 10) & CMASK);
    run(12);
    check("R9 no reset when wden clear", 32'(wdt_reset_req), 0);

    // restart and fire after exactly T ticks
    wr(8'h28, 1); wr(8'h20, 32'h3F);
    wr(8'h30, 1); rd(8'h34, s); wr(chan_off(WCH)[7:0], (s + 10) & CMASK);
    rd(8'h00, c); rd(chan_off(WCH)[7:0], mt);
    check("R9 time remaining", remaining(mt, c), 10);
    run(9);
    check("R9 not yet", 32'(wdt_reset_req), 0);
    run(1);
    check("R9 fired on tick T", 32'(wdt_reset_req), 1);

    // R10 sticky
    wr(8'h20, 32'h3F); wr(8'h28, 0); wr(8'h24, 0);
    repeat (5) @(posedge clk); #1;
    check("R10 sticky", 32'(wdt_reset_req), 1);
    do_reset(); #1;
    check("R10 cleared by reset", 32'(wdt_reset_req), 0);
    rd(8'h28, v); check("R1 wden after reset", v, 0);
    rd(8'h00, v); check("R1 counter after reset", v, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule